// File: doc/BRIEF.md
# Fractional-Rate Serial Clock Generator

This block derives a serial bit clock from a fast reference tick. A 32-bit control word selects an integer half-period width A and two counts, B and C. Each generated level state lasts a whole number of ticks: either the short width A or the long width A+1. The average output rate therefore falls between the two integer divisions, at tick_rate / (2 * (A + (B + 1)/(C + 1))). With a tick of about 133 MHz, that rate is base / (A + (B + 1)/(C + 1)) against a base of half the tick rate.

One sequence is a block of short states followed by a block of long states. The block does not interleave the long states the way a phase accumulator would. When the sequence ends, it starts again. The level toggles on every state boundary, including the boundary between two sequences, so no two adjacent states share a level.

A one-tick pulse marks the last tick of every sequence. A replacement control word waits for the end of the current sequence, so a half-period is never cut short. Enable gates the whole generator.

Top module: `fracn_clkgen`

## Requirements
- R1: The control word is split as A = bits 31:22, B = bits 21:12 and C = bits 11:0. With A=2, B=2, C=7 the first 19 ticks of `clk_out` are 1100110011 followed by 000111000.
- R2: One sequence is (C-B) short states, each A ticks wide, followed by (B+1) long states, each A+1 ticks wide. Its length is (C-B)*A + (B+1)*(A+1) ticks, and it then repeats.
- R3: The level of `clk_out` inverts at every state boundary, within a sequence and between sequences. The first state after the generator starts is 1.
- R4: `seq_end` is high for exactly the last tick of each sequence and low on every other tick.
- R5: A word loaded while the generator runs takes effect from the first tick of the next sequence. The current sequence finishes with the old word. A word loaded on the last tick of a sequence applies to the next sequence directly, and a later load replaces an earlier pending one.
- R6: When C <= B there are no short states, and the sequence consists only of the (B+1) long states.
- R7: When A = 0, each short state is 1 tick wide and each long state is 1 tick wide.
- R8: While `en` is low, `clk_out` and `seq_end` are 0 from the next tick, and a load takes effect at once. When `en` rises, the tick after the sampling edge is tick 0 of a new sequence with level 1.
- R9: After the synchronous reset, `clk_out` and `seq_end` are 0 and no word is held. Until the first load, the outputs stay 0 even with `en` high. The first load is applied immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference tick clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; the output is held low when 0 |
| ctrl_word | input | 32 | Control word holding the fields A, B and C |
| ctrl_load | input | 1 | One-tick strobe that captures `ctrl_word` |
| clk_out | output | 1 | Generated serial clock level |
| seq_end | output | 1 | High on the last tick of each sequence |

## Verification
Both outputs are registered, so the tick decided at one rising edge shows up just after that edge. A load, or a change of `en`, sampled at an edge affects the output one edge later. The bench changes inputs on the falling edge and advances its own tick-index model of the next edge's result. It compares that model against the outputs on the following falling edge, which keeps every comparison exactly one register stage behind its stimulus. Directed patterns check the documented example and the corner cases C<=B and A=0 tick by tick. Random words, loads and enable drops check the deferred-load rule and the restart rule.

// File: rtl/fracn_pkg.sv
package fracn_pkg;

    parameter int A_W    = 10;
    parameter int B_W    = 10;
    parameter int C_W    = 12;
    localparam int WORD_W = A_W + B_W + C_W;
    localparam int TICK_W = A_W + 1;
    localparam int CNT_W  = C_W + 1;

    typedef struct packed {
        logic [A_W-1:0] a;
        logic [B_W-1:0] b;
        logic [C_W-1:0] c;
    } ctrl_t;

    typedef enum logic {
        PH_SHORT = 1'b0,
        PH_LONG  = 1'b1
    } phase_t;

    function automatic logic [CNT_W-1:0] short_states(input ctrl_t w);
        logic [CNT_W-1:0] cc;
        logic [CNT_W-1:0] bb;
        cc = CNT_W'(w.c);
        bb = CNT_W'(w.b);
        return (cc > bb) ? (cc - bb) : '0;
    endfunction

    function automatic logic [CNT_W-1:0] long_states(input ctrl_t w);
        return CNT_W'(w.b) + CNT_W'(1);
    endfunction

    function automatic logic [TICK_W-1:0] short_width(input ctrl_t w);
        return (w.a == '0) ? TICK_W'(1) : TICK_W'(w.a);
    endfunction

    function automatic logic [TICK_W-1:0] long_width(input ctrl_t w);
        return TICK_W'(w.a) + TICK_W'(1);
    endfunction

    function automatic phase_t start_phase(input ctrl_t w);
        return (short_states(w) == '0) ? PH_LONG : PH_SHORT;
    endfunction

endpackage

// File: rtl/fracn_word_hold.sv
module fracn_word_hold
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic              seq_last,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    output ctrl_t             cur,
    output ctrl_t             nxt,
    output logic              armed
);

    ctrl_t pend;
    logic  pend_v;
    logic  boundary;

    assign boundary = !run || seq_last;

    always_comb begin
        nxt = cur;
        if (boundary) begin
            if (load)
                nxt = ctrl_t'(word);
            else if (pend_v)
                nxt = pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            pend   <= '0;
            pend_v <= 1'b0;
            armed  <= 1'b0;
        end else if (boundary) begin
            cur    <= nxt;
            pend_v <= 1'b0;
            if (load)
                armed <= 1'b1;
        end else if (load) begin
            pend   <= ctrl_t'(word);
            pend_v <= 1'b1;
        end
    end

    // R5
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !seq_last) |=> $stable(cur));

    // R9
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!armed && !load) |=> !armed);

endmodule

// File: rtl/fracn_seq_core.sv
module fracn_seq_core
    import fracn_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  run,
    input  ctrl_t cur,
    input  ctrl_t nxt,
    output logic  seq_last,
    output logic  level_o,
    output logic  end_o
);

    phase_t            phase;
    logic [TICK_W-1:0] tick_cnt;
    logic [CNT_W-1:0]  st_cnt;
    logic              level;

    logic [CNT_W-1:0]  n_short;
    logic [CNT_W-1:0]  n_long;
    logic [CNT_W-1:0]  n_phase;
    logic [TICK_W-1:0] width;
    logic              st_end;
    logic              ph_last;

    always_comb begin
        n_short = short_states(cur);
        n_long  = long_states(cur);
        if (phase == PH_SHORT) begin
            width   = short_width(cur);
            n_phase = n_short;
        end else begin
            width   = long_width(cur);
            n_phase = n_long;
        end
        st_end   = (tick_cnt == width - TICK_W'(1));
        ph_last  = (st_cnt == n_phase - CNT_W'(1));
        seq_last = run && st_end && ph_last && (phase == PH_LONG);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            tick_cnt <= '0;
            st_cnt   <= '0;
            phase    <= start_phase(nxt);
            level    <= 1'b1;
            level_o  <= 1'b0;
            end_o    <= 1'b0;
        end else begin
            level_o <= level;
            end_o   <= seq_last;
            if (st_end) begin
                tick_cnt <= '0;
                level    <= ~level;
                if (ph_last) begin
                    st_cnt <= '0;
                    if (phase == PH_SHORT)
                        phase <= PH_LONG;
                    else
                        phase <= start_phase(nxt);
                end else begin
                    st_cnt <= st_cnt + CNT_W'(1);
                end
            end else begin
                tick_cnt <= tick_cnt + TICK_W'(1);
            end
        end
    end

    // R2
    tick_bound_chk: assert property (@(posedge clk) disable iff (rst)
        run |-> (tick_cnt < width));

    // R3
    level_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (run && !st_end) |=> $stable(level));

    // R6
    skip_short_chk: assert property (@(posedge clk) disable iff (rst)
        (run && phase == PH_SHORT) |-> (n_short != '0));

endmodule

// File: rtl/fracn_clkgen.sv
module fracn_clkgen
    import fracn_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [WORD_W-1:0] ctrl_word,
    input  logic              ctrl_load,
    output logic              clk_out,
    output logic              seq_end
);

    ctrl_t cur;
    ctrl_t nxt;
    logic  armed;
    logic  run;
    logic  seq_last;

    assign run = en && armed;

    fracn_word_hold u_hold (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .seq_last (seq_last),
        .load     (ctrl_load),
        .word     (ctrl_word),
        .cur      (cur),
        .nxt      (nxt),
        .armed    (armed)
    );

    fracn_seq_core u_core (
        .clk      (clk),
        .rst      (rst),
        .run      (run),
        .cur      (cur),
        .nxt      (nxt),
        .seq_last (seq_last),
        .level_o  (clk_out),
        .end_o    (seq_end)
    );

    // R8
    idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!clk_out && !seq_end));

    // R4
    end_mark_chk: assert property (@(posedge clk) disable iff (rst)
        seq_last |=> seq_end);

    // R9
    unarmed_low_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !clk_out);

endmodule

// File: tb/sim_fracn_clkgen.sv
module sim_fracn_clkgen;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic [31:0] ctrl_word = '0;
    logic        ctrl_load = 1'b0;
    logic        clk_out;
    logic        seq_end;

    always #4 clk = ~clk;

    fracn_clkgen u0 (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ctrl_word (ctrl_word),
        .ctrl_load (ctrl_load),
        .clk_out   (clk_out),
        .seq_end   (seq_end)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    // model state
    bit        m_armed, m_pv, m_lvl, exp_out, exp_end;
    bit [31:0] m_cur, m_pend;
    int        m_si, m_ti;
    bit        last_out, last_end;

    function automatic int f_a(input bit [31:0] w); return int'(w[31:22]); endfunction
    function automatic int f_b(input bit [31:0] w); return int'(w[21:12]); endfunction
    function automatic int f_c(input bit [31:0] w); return int'(w[11:0]);  endfunction
    function automatic int n_s(input bit [31:0] w);
        return (f_c(w) > f_b(w)) ? f_c(w) - f_b(w) : 0;
    endfunction
    function automatic int w_of(input bit [31:0] w, input int si);
        if (si < n_s(w)) return (f_a(w) == 0) ? 1 : f_a(w);
        return f_a(w) + 1;
    endfunction
    function automatic bit [31:0] mk(input int a, input int b, input int c);
        return {a[9:0], b[9:0], c[11:0]};
    endfunction

    task automatic chk(input string tag, input bit act, input bit exp, input string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at cycle %0d", tag, what, act, exp, cycles);
        end
    endtask

    task automatic model_step(input bit e, input bit ld, input bit [31:0] w);
        bit run, lst, bnd;
        int tot;
        run = e && m_armed;
        if (run) begin
            tot     = n_s(m_cur) + f_b(m_cur) + 1;
            exp_out = m_lvl;
            lst     = (m_ti == w_of(m_cur, m_si) - 1);
            exp_end = lst && (m_si == tot - 1);
            if (lst) begin
                m_lvl = ~m_lvl;
                m_ti  = 0;
                m_si  = exp_end ? 0 : m_si + 1;
            end else begin
                m_ti++;
            end
        end else begin
            exp_out = 0; exp_end = 0;
            m_si = 0; m_ti = 0; m_lvl = 1;
        end
        bnd = !run || exp_end;
        if (bnd) begin
            if (ld) begin m_cur = w; m_armed = 1; end
            else if (m_pv) m_cur = m_pend;
            m_pv = 0;
        end else if (ld) begin
            m_pend = w; m_pv = 1;
        end
    endtask

    // sample outputs of the previous edge, then drive and model the next edge
    task automatic cyc(input string tag, input bit e, input bit ld, input bit [31:0] w);
        @(negedge clk);
        last_out = clk_out;
        last_end = seq_end;
        chk(tag, clk_out, exp_out, "clk_out");
        chk(tag, seq_end, exp_end, "seq_end");
        en = e; ctrl_load = ld; ctrl_word = w;
        model_step(e, ld, w);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; en = 0; ctrl_load = 0;
        m_armed = 0; m_pv = 0; m_cur = 0; m_pend = 0;
        m_si = 0; m_ti = 0; m_lvl = 1; exp_out = 0; exp_end = 0;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    // load idle, then run n ticks collecting the pattern
    task automatic pattern(input string tag, input bit [31:0] w, input int n,
                           input bit [63:0] exp_pat, input int exp_ends);
        bit [63:0] pat;
        int ends;
        pat = '0; ends = 0;
        cyc(tag, 0, 1, w);
        cyc(tag, 0, 0, 0);
        for (int i = 0; i <= n; i++) begin
            cyc(tag, 1, 0, 0);
            if (i > 0) begin
                pat = {pat[62:0], last_out};
                if (last_end) ends++;
            end
        end
        n_chk++;
        if (pat !== exp_pat) begin
            n_fail++;
            $display("FAIL %s pattern: actual %b expected %b", tag, pat[31:0], exp_pat[31:0]);
        end
        n_chk++;
        if (ends != exp_ends || !last_end) begin
            n_fail++;
            $display("FAIL %s seq_end count: actual %0d expected %0d (last %0b expected 1)",
                     tag, ends, exp_ends, last_end);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected under 150000", cycles);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        do_reset();
        // R9: reset state and no run before the first load
        for (int i = 0; i < 6; i++) cyc("R9", 1, 0, 0);
        // R1 / R2 / R3 / R4: example word, 19 ticks
        pattern("R1", mk(2, 2, 7), 19, 64'b1100110011000111000, 1);
        // R7: A=0 gives 1-tick states: 3 short + 2 long
        pattern("R7", mk(0, 1, 4), 5, 64'b10101, 1);
        // R6: C<B, only 4 long states of 2 ticks
        pattern("R6", mk(1, 3, 1), 8, 64'b11001100, 1);
        // R6: C==B, 2 long states of 3 ticks
        pattern("R6", mk(2, 1, 1), 6, 64'b111000, 1);
        // R3: odd state count keeps alternating across sequences (3 states of 1 tick)
        pattern("R3", mk(0, 2, 0), 6, 64'b101010, 2);
        // R5: reload mid-sequence, tracked per tick by the model
        cyc("R5", 1, 1, mk(3, 0, 2));
        for (int i = 0; i < 40; i++) cyc("R5", 1, 0, 0);
        // R8: drop enable then restart
        for (int i = 0; i < 4; i++) cyc("R8", 0, 0, 0);
        for (int i = 0; i < 10; i++) cyc("R8", 1, 0, 0);
        // random mix
        for (int i = 0; i < 6000; i++) begin
            bit e, ld;
            bit [31:0] w;
            e  = ($urandom % 50) != 0;
            ld = ($urandom % 30) == 0;
            w  = mk($urandom % 5, $urandom % 6, $urandom % 10);
            cyc(m_pv ? "R5" : (e ? "R2" : "R8"), e, ld, w);
        end
        // R9: reset again mid-run
        do_reset();
        for (int i = 0; i < 4; i++) cyc("R9", 1, 0, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule